// File: doc/BRIEF.md
# Coprocessor Sub-word Load/Store Unit

This unit carries out one byte or halfword memory transfer between a coprocessor register and a 32-bit little-endian synchronous data memory. The caller supplies an already decoded operation, a 32-bit base register value, a displacement and an addressing mode. The operation is a store, a signed load or an unsigned load, at byte or halfword size.

In displacement mode the unit accesses base plus a sign-extended 12-bit displacement. In post-increment mode it accesses the base itself and returns an updated base for the register file. The unit produces the memory request with its byte enables and replicated write data. It also extends the selected load lane to 32 bits and reports misaligned or illegal operations without touching memory.

Each operation is taken with a valid/ready handshake. It is issued to memory in the following cycle and held until granted. It is answered by a single-cycle response pulse that carries the load result, the base writeback and any error flag.

Top module: `cp_mem_unit`

## Requirements
- R1: In displacement mode (`req_postinc`=0) the access address is `req_base` plus `req_disp[11:0]` sign-extended to 32 bits, modulo 2^32. `mem_addr` carries this full byte address.
- R2: Operation codes on `req_kind` are 0 = store, 1 = signed load, 2 = unsigned load and 3 = reserved. `req_half`=1 selects halfword size, 0 selects byte size. A byte access enables only lane `addr[1:0]` of `mem_be` (bit i = byte i, bits [8i+7:8i]). A halfword access enables lanes 0 and 1 (`4'b0011`) when `addr[1]`=0, and lanes 2 and 3 (`4'b1100`) when it is 1. `mem_we` is 1 for stores only.
- R3: A store drives only the low 8 bits (byte) or low 16 bits (halfword) of `req_cdata`, replicated on every byte lane or both halfword lanes of `mem_wdata`.
- R4: A signed load returns the addressed byte or halfword of the memory word, sign-extended to 32 bits on `rsp_data`.
- R5: An unsigned load returns the addressed byte or halfword zero-extended to 32 bits on `rsp_data`.
- R6: In post-increment mode the access uses `req_base` unchanged, except that bit 0 is cleared for halfword accesses. With the response, `wb_valid` is 1 and `wb_base` equals `req_base` plus `req_disp[9:0]` sign-extended to 32 bits.
- R7: In displacement mode a halfword access with address bit 0 set is never sent to memory. Its response carries `err_misalign`=1.
- R8: An operation accepted while `cp_present`=0, or with code 3, is never sent to memory. Its response carries `err_illegal`=1 and `err_misalign`=0.
- R9: `req_ready` is 1 only while the unit is idle. After acceptance, `mem_req` rises in the next cycle and holds a stable address and byte enables until `mem_gnt`. `rsp_valid` pulses for one cycle, one cycle after the grant. For an errored operation it pulses in the cycle right after acceptance.
- R10: `rsp_data` is 0 for stores and for errored operations. `wb_valid` is 0 in displacement mode and for errored operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_present | input | 1 | Coprocessor option enabled |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Unit idle, operation taken this cycle |
| req_kind | input | 2 | 0 store, 1 signed load, 2 unsigned load, 3 reserved |
| req_half | input | 1 | 1 halfword, 0 byte |
| req_postinc | input | 1 | 1 post-increment mode, 0 displacement mode |
| req_base | input | 32 | Base register value |
| req_disp | input | 12 | Displacement (low 10 bits used in post-increment mode) |
| req_cdata | input | 16 | Low half of the coprocessor register for stores |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data, lanes replicated |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read word, valid the cycle after a read grant |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Extended load result |
| err_misalign | output | 1 | Misaligned halfword, not issued |
| err_illegal | output | 1 | Illegal operation, not issued |
| wb_valid | output | 1 | Base writeback present |
| wb_base | output | 32 | Updated base |

## Verification
On every cycle, the assertions check the handshake sequencing: a request is held steady until it is granted, responses last one cycle, and the unit is not ready while busy. They also check that the byte-enable count is one or two, that two-lane requests have address bit 0 clear, and that errors never come with a writeback or load data. An illegal operation must answer in the very next cycle without a memory request. Only the bench's sweeps can show the arithmetic: the sign-extended displacement sums, the lane chosen for each address offset, the sign or zero extension of each lane value, and the post-increment result. It sweeps every operation code, size, mode and address offset over positive, negative and wrapping displacements, with varied grant delays.

// File: rtl/cp_mem_pkg.sv
package cp_mem_pkg;

    localparam int XLEN    = 32;
    localparam int DISP_W  = 12;
    localparam int PINC_W  = 10;
    localparam int CDATA_W = 16;

    typedef enum logic [1:0] {
        CPM_STORE  = 2'd0,
        CPM_LOAD_S = 2'd1,
        CPM_LOAD_U = 2'd2,
        CPM_RSVD   = 2'd3
    } cpm_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } cpm_state_e;

    typedef struct packed {
        cpm_kind_e           kind;
        logic                half;
        logic                postinc;
        logic                err_ill;
        logic                err_mis;
        logic [XLEN-1:0]     addr;
        logic [XLEN-1:0]     next_base;
        logic [CDATA_W-1:0]  cdata;
    } cpm_op_t;

    function automatic logic is_load(cpm_kind_e k);
        return (k == CPM_LOAD_S) || (k == CPM_LOAD_U);
    endfunction

endpackage

// File: rtl/cpm_addr_gen.sv
module cpm_addr_gen
    import cp_mem_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int DW = DISP_W,
    parameter int PW = PINC_W
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] disp,
    input  logic          half,
    input  logic          postinc,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] next_base,
    output logic          misalign
);
    logic [AW-1:0] disp_ext;
    logic [AW-1:0] pinc_ext;

    assign disp_ext = {{(AW-DW){disp[DW-1]}}, disp};
    assign pinc_ext = {{(AW-PW){disp[PW-1]}}, disp[PW-1:0]};

    always_comb begin
        if (postinc) begin
            ea = base;
            if (half) begin
                ea[0] = 1'b0;
            end
        end else begin
            ea = base + disp_ext;
        end
    end

    assign next_base = base + pinc_ext;
    assign misalign  = !postinc && half && ea[0];
endmodule

// File: rtl/cpm_lane_ctrl.sv
module cpm_lane_ctrl
    import cp_mem_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int CW = CDATA_W
) (
    input  logic [$clog2(AW/8)-1:0] lane,
    input  logic                    half,
    input  logic [CW-1:0]           cdata,
    output logic [AW/8-1:0]         be,
    output logic [AW-1:0]           wdata
);
    localparam int LANES = AW / 8;
    localparam int LW    = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [LW-1:0] BIDX = LW'(i);
        localparam logic [LW-2:0] HIDX = (LW-1)'(i / 2);
        assign be[i] = half ? (lane[LW-1:1] == HIDX) : (lane == BIDX);
        assign wdata[8*i +: 8] = half ? cdata[8*(i%2) +: 8] : cdata[7:0];
    end
endmodule

// File: rtl/cpm_load_ext.sv
module cpm_load_ext
    import cp_mem_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  logic [$clog2(AW/8)-1:0] lane,
    input  logic                    half,
    input  logic                    sign_ext,
    input  logic [AW-1:0]           rdata,
    output logic [AW-1:0]           result
);
    localparam int LW = $clog2(AW/8);

    logic [7:0]  bsel;
    logic [15:0] hsel;

    assign bsel = rdata[{lane, 3'b000} +: 8];
    assign hsel = rdata[{lane[LW-1:1], 4'b0000} +: 16];

    always_comb begin
        if (half) begin
            result = {{(AW-16){sign_ext & hsel[15]}}, hsel};
        end else begin
            result = {{(AW-8){sign_ext & bsel[7]}}, bsel};
        end
    end
endmodule

// File: rtl/cp_mem_unit.sv
module cp_mem_unit
    import cp_mem_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int DW = DISP_W,
    parameter int PW = PINC_W,
    parameter int CW = CDATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cp_present,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_kind,
    input  logic            req_half,
    input  logic            req_postinc,
    input  logic [AW-1:0]   req_base,
    input  logic [DW-1:0]   req_disp,
    input  logic [CW-1:0]   req_cdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [AW/8-1:0] mem_be,
    output logic [AW-1:0]   mem_wdata,
    input  logic            mem_gnt,
    input  logic [AW-1:0]   mem_rdata,
    output logic            rsp_valid,
    output logic [AW-1:0]   rsp_data,
    output logic            err_misalign,
    output logic            err_illegal,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_base
);
    localparam int LW = $clog2(AW/8);

    cpm_state_e    state_q;
    cpm_op_t       op_q;
    cpm_kind_e     kind_in;
    logic [AW-1:0] ea;
    logic [AW-1:0] next_base;
    logic          misalign;
    logic          accept;
    logic          illegal_in;
    logic [AW-1:0] load_val;

    assign kind_in    = cpm_kind_e'(req_kind);
    assign accept     = req_valid && (state_q == ST_IDLE);
    assign illegal_in = !cp_present || (kind_in == CPM_RSVD);

    cpm_addr_gen #(.AW(AW), .DW(DW), .PW(PW)) i_addr (
        .base      (req_base),
        .disp      (req_disp),
        .half      (req_half),
        .postinc   (req_postinc),
        .ea        (ea),
        .next_base (next_base),
        .misalign  (misalign)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q.kind      <= kind_in;
                        op_q.half      <= req_half;
                        op_q.postinc   <= req_postinc;
                        op_q.err_ill   <= illegal_in;
                        op_q.err_mis   <= !illegal_in && misalign;
                        op_q.addr      <= ea;
                        op_q.next_base <= next_base;
                        op_q.cdata     <= req_cdata;
                        state_q <= (illegal_in || misalign) ? ST_RESP : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_gnt) begin
                        state_q <= ST_RESP;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_req   = (state_q == ST_ISSUE);
    assign mem_we    = (op_q.kind == CPM_STORE);
    assign mem_addr  = op_q.addr;

    cpm_lane_ctrl #(.AW(AW), .CW(CW)) i_lanes (
        .lane  (op_q.addr[LW-1:0]),
        .half  (op_q.half),
        .cdata (op_q.cdata),
        .be    (mem_be),
        .wdata (mem_wdata)
    );

    cpm_load_ext #(.AW(AW)) i_ext (
        .lane     (op_q.addr[LW-1:0]),
        .half     (op_q.half),
        .sign_ext (op_q.kind == CPM_LOAD_S),
        .rdata    (mem_rdata),
        .result   (load_val)
    );

    assign rsp_valid    = (state_q == ST_RESP);
    assign err_illegal  = rsp_valid && op_q.err_ill;
    assign err_misalign = rsp_valid && op_q.err_mis;
    assign rsp_data     = (rsp_valid && is_load(op_q.kind) && !op_q.err_ill && !op_q.err_mis)
                          ? load_val : '0;
    assign wb_valid     = rsp_valid && op_q.postinc && !op_q.err_ill && !op_q.err_mis;
    assign wb_base      = op_q.next_base;
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
    parameter int AW = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            cp_present,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req,
    input logic            mem_gnt,
    input logic [AW-1:0]   mem_addr,
    input logic [AW/8-1:0] mem_be,
    input logic            rsp_valid,
    input logic [AW-1:0]   rsp_data,
    input logic            err_misalign,
    input logic            err_illegal,
    input logic            wb_valid
);
    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req || rsp_valid) |-> !req_ready);

    // R2
    be_count_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2));

    // R7
    half_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $countones(mem_be) == 2) |-> (mem_addr[0] == 1'b0));

    // R8
    illegal_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !cp_present) |=> (rsp_valid && err_illegal && !mem_req));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (err_misalign || err_illegal) |-> (!wb_valid && rsp_data == '0));

    // R7
    err_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(err_misalign && err_illegal));
endmodule

bind cp_mem_unit cpm_checker #(.AW(AW)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .cp_present   (cp_present),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_req      (mem_req),
    .mem_gnt      (mem_gnt),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .err_misalign (err_misalign),
    .err_illegal  (err_illegal),
    .wb_valid     (wb_valid)
);

// File: tb/test_cp_mem_unit.sv
`timescale 1ns/1ps
module test_cp_mem_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cp_present = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic        req_half = 1'b0;
    logic        req_postinc = 1'b0;
    logic [31:0] req_base = '0;
    logic [11:0] req_disp = '0;
    logic [15:0] req_cdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_gnt;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, err_misalign, err_illegal, wb_valid;
    logic [31:0] rsp_data, wb_base;

    int checks = 0;
    int failures = 0;
    int gnt_delay = 0;
    int wait_cnt = 0;
    int seen_cnt = 0;
    logic [31:0] seen_addr, seen_wdata;
    logic [3:0]  seen_be;
    logic        seen_we;

    always #4 clk = ~clk;

    cp_mem_unit i_cp_mem_unit (
        .clk(clk), .rst(rst), .cp_present(cp_present),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_half(req_half), .req_postinc(req_postinc), .req_base(req_base),
        .req_disp(req_disp), .req_cdata(req_cdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err_misalign(err_misalign),
        .err_illegal(err_illegal), .wb_valid(wb_valid), .wb_base(wb_base)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        logic [7:0] s;
        s = a[9:2] ^ a[31:24];
        return 32'h9E37_79B9 ^ {s, s ^ 8'h5A, ~s, s + 8'h3C};
    endfunction

    assign mem_gnt = mem_req && (wait_cnt >= gnt_delay);

    always @(posedge clk) begin
        if (rst) begin
            wait_cnt <= 0;
        end else if (mem_req && !mem_gnt) begin
            wait_cnt <= wait_cnt + 1;
        end else begin
            wait_cnt <= 0;
        end
        if (mem_req && mem_gnt) begin
            seen_cnt   <= seen_cnt + 1;
            seen_addr  <= mem_addr;
            seen_be    <= mem_be;
            seen_wdata <= mem_wdata;
            seen_we    <= mem_we;
            if (!mem_we) mem_rdata <= pat(mem_addr);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input int kind, input bit half, input bit pinc,
                          input logic [31:0] base, input logic [11:0] disp,
                          input logic [15:0] cd, input bit cp, input int dly);
        logic [31:0] ea, w, exp_data, exp_wdata, exp_wb;
        logic [3:0]  exp_be;
        logic [7:0]  b;
        logic [15:0] h;
        bit ill, mis, issued;
        int start, idx;
        ea = pinc ? base : base + {{20{disp[11]}}, disp};
        if (pinc && half) ea[0] = 1'b0;
        ill = !cp || (kind == 3);
        mis = !ill && !pinc && half && ea[0];
        issued = !ill && !mis;
        exp_be = half ? (ea[1] ? 4'b1100 : 4'b0011) : (4'b0001 << ea[1:0]);
        exp_wdata = half ? {2{cd}} : {4{cd[7:0]}};
        w = pat(ea);
        b = w[8*ea[1:0] +: 8];
        h = w[16*ea[1] +: 16];
        if (!issued || kind == 0) exp_data = 32'h0;
        else if (half) exp_data = {{16{(kind == 1) & h[15]}}, h};
        else exp_data = {{24{(kind == 1) & b[7]}}, b};
        exp_wb = base + {{22{disp[9]}}, disp[9:0]};

        @(negedge clk);
        gnt_delay = dly;
        cp_present = cp; req_kind = 2'(kind); req_half = half; req_postinc = pinc;
        req_base = base; req_disp = disp; req_cdata = cd; req_valid = 1'b1;
        start = seen_cnt;
        chk("R9 ready when idle", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        idx = 0;
        while (!rsp_valid && idx < 40) begin
            @(negedge clk);
            idx++;
        end
        chk("R9 response latency", idx, issued ? dly + 1 : 0);
        chk("R8 illegal flag", {31'b0, err_illegal}, {31'b0, ill});
        chk("R7 misalign flag", {31'b0, err_misalign}, {31'b0, mis});
        chk("R8 R7 memory touched", seen_cnt - start, issued ? 1 : 0);
        if (issued) begin
            chk(pinc ? "R6 access address" : "R1 access address", seen_addr, ea);
            chk("R2 byte enables", {28'b0, seen_be}, {28'b0, exp_be});
            chk("R2 write flag", {31'b0, seen_we}, {31'b0, kind == 0});
            if (kind == 0) chk("R3 store data", seen_wdata, exp_wdata);
        end
        if (kind == 1) chk("R4 signed load data", rsp_data, exp_data);
        else if (kind == 2) chk("R5 unsigned load data", rsp_data, exp_data);
        else chk("R10 data zero", rsp_data, exp_data);
        chk("R10 R6 writeback valid", {31'b0, wb_valid}, {31'b0, pinc && !ill});
        if (pinc && !ill) chk("R6 writeback base", wb_base, exp_wb);
        @(negedge clk);
        chk("R9 single response", {31'b0, rsp_valid}, 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [11:0] dtab [7];
        dtab[0] = 12'h000; dtab[1] = 12'h001; dtab[2] = 12'h7FF; dtab[3] = 12'h800;
        dtab[4] = 12'hFFF; dtab[5] = 12'h203; dtab[6] = 12'h1FE;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9 reset ready", {31'b0, req_ready}, 32'd1);
        chk("R9 reset no request", {31'b0, mem_req}, 32'd0);
        chk("R9 reset no response", {31'b0, rsp_valid}, 32'd0);
        for (int k = 0; k < 4; k++)
            for (int hh = 0; hh < 2; hh++)
                for (int p = 0; p < 2; p++)
                    for (int lo = 0; lo < 4; lo++)
                        for (int di = 0; di < 7; di++)
                            run_op(k, hh[0], p[0], 32'h0040_1000 + 32'(lo) + 32'(di * 68),
                                   dtab[di], 16'h8A00 ^ 16'(lo * 4099 + di * 37),
                                   1'b1, (lo + di) % 3);
        // R1 wrap below zero, R6 wrap of writeback
        run_op(1, 1'b0, 1'b0, 32'h0000_0002, 12'hFFC, 16'h0, 1'b1, 0);
        run_op(2, 1'b1, 1'b1, 32'h0000_0003, 12'h3F8, 16'h0, 1'b1, 2);
        run_op(1, 1'b1, 1'b0, 32'hFFFF_FFFE, 12'h004, 16'h0, 1'b1, 1);
        // R8 coprocessor absent sweep
        for (int k = 0; k < 4; k++)
            for (int p = 0; p < 2; p++)
                run_op(k, p[0], p[0], 32'h0000_2005, 12'h011, 16'hBEEF, 1'b0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule